// File: doc/BRIEF.md
# Frame-Slot GPIO Controller

This block sits on the codec side of a time-division serial audio link. It owns a bank of general-purpose pins, and the host controls them through one data slot per frame instead of through register command and status traffic. A serializer outside the block hands over the received slot as a parallel word, together with a one-cycle frame strobe. At every strobe the block latches new output levels and returns a status word for the serializer to send back.

Each pin is either an input or an output, as set in a direction register. An output pin drives the value from its bit of the latest received slot. Slot bits at input-pin positions are dropped. Input pins pass through a two-flop synchronizer. Their levels are captured into the outgoing slot, so the host always sees status at least one frame late. A change on any input pin sets a sticky interrupt flag.

A power register gates the whole bank. The block comes out of reset powered down, with every pad released. After the host clears the power-down bit, a ready flag rises a fixed number of frames later. Only then do pads drive and status bits report levels.

Top module: `fslot_gpio_ctrl`

## Requirements
- R1: After reset, pad_oe and pad_out are 0, tx_slot is 0, irq is 0 and the direction register (address 0) reads 0.
- R2: Pin i takes slot bit i+4. A direction bit of 1 makes that pin an output. At each frame strobe, output pins latch their bit of rx_slot. While ready, pad_oe equals the direction register and pad_out carries the latched values on enabled pins. Slot bits 3:0 have no effect.
- R3: At a frame strobe, rx_slot bits at input-pin positions do not change that pin's latch. Switching the pin to output afterwards shows its earlier value on pad_out, not the ignored bit.
- R4: At each frame strobe, tx_slot bit i+4 is loaded with the synchronized level of pin i if it is an input. Bits at output-pin positions and bits 3:0 are 0. tx_slot holds its value between strobes.
- R5: A level driven out by the slot received at one strobe and looped back to an input pin is absent from the tx_slot loaded at that same strobe. It appears at the next strobe.
- R6: While not ready, pad_oe and pad_out are 0, and every tx_slot loaded is 0.
- R7: The power register at address 1 resets to 0x0100. Bit 8 is power-down and is writable. Bit 0 is the read-only ready flag. All other bits read 0, whatever was written to them.
- R8: With power-down at 0, ready rises at the third frame strobe and not before. Setting power-down clears ready.
- R9: While ready, a change in the synchronized level of an input-configured pin sets irq. Changes on output-configured pins do not.
- R10: irq stays set until a write to address 2 with bit 0 = 1. A write with bit 0 = 0 leaves it set. Address 2 reads irq in bit 0.
- R11: The direction register at address 0 stores and reads back all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle frame strobe; rx_slot valid |
| rx_slot | input | 20 | Received GPIO slot word |
| tx_slot | output | 20 | Status slot word to transmit |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 direction, 1 power, 2 interrupt |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pad_in | input | 16 | Pin levels from pads |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| irq | output | 1 | Sticky input-change interrupt |

## Verification
A corrupted output latch shows on pad_out as soon as the pin is enabled. A latch that wrongly took an input-position bit is exposed by switching that pin to output before the next strobe. A broken settle counter shows up at the power register: ready rises at the wrong strobe, and pad_oe follows it in the same cycle. Wrong synchronizer depth or missing slot registration breaks the loopback latency, which the tx_slot of the very next frame reveals. A lost sticky bit shows on irq within a cycle of the clearing write.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int PIN_N         = 16;
    localparam int SLOT_W        = 20;
    localparam int REG_W         = 16;
    localparam int SETTLE_FRAMES = 3;
    localparam int PWR_PD_BIT    = 8;
    localparam int PWR_RDY_BIT   = 0;

    typedef enum logic [1:0] {
        RA_DIR  = 2'd0,
        RA_PWR  = 2'd1,
        RA_IRQ  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic pd;
        logic ready;
    } pwr_state_t;

    function automatic logic [REG_W-1:0] pwr_word(pwr_state_t s);
        logic [REG_W-1:0] w;
        w              = '0;
        w[PWR_PD_BIT]  = s.pd;
        w[PWR_RDY_BIT] = s.ready;
        return w;
    endfunction

endpackage

// File: rtl/fsg_sync.sv
module fsg_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/fsg_power.sv
module fsg_power
    import fsg_pkg::*;
#(
    parameter int SETTLE = SETTLE_FRAMES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    input  logic       wr_en,
    input  logic       wr_pd,
    output pwr_state_t state
);
    localparam int CW = $clog2(SETTLE + 1);

    logic          pd_q, rdy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q  <= 1'b1;
            rdy_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (wr_en) pd_q <= wr_pd;
            if (pd_q) begin
                rdy_q <= 1'b0;
                cnt_q <= '0;
            end else if (frame_stb && !rdy_q) begin
                if (cnt_q == CW'(SETTLE - 1)) rdy_q <= 1'b1;
                else                          cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign state.pd    = pd_q;
    assign state.ready = rdy_q;
endmodule

// File: rtl/fsg_change_irq.sv
module fsg_change_irq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] watch,
    input  logic         enable,
    input  logic         clr,
    output logic         flag
);
    logic [W-1:0] prev_q;
    logic         hit;

    assign hit = enable && (|((lvl ^ prev_q) & watch));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag   <= 1'b0;
        end else begin
            prev_q <= lvl;
            flag   <= hit | (flag & ~clr);
        end
    end
endmodule

// File: rtl/fslot_gpio_ctrl.sv
module fslot_gpio_ctrl
    import fsg_pkg::*;
#(
    parameter int NPIN      = PIN_N,
    parameter int SLOT_BITS = SLOT_W,
    parameter int SETTLE    = SETTLE_FRAMES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_stb,
    input  logic [SLOT_BITS-1:0] rx_slot,
    output logic [SLOT_BITS-1:0] tx_slot,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NPIN-1:0]      pad_in,
    output logic [NPIN-1:0]      pad_out,
    output logic [NPIN-1:0]      pad_oe,
    output logic                 irq
);
    localparam int LO = SLOT_BITS - NPIN;

    reg_addr_e             addr;
    logic [NPIN-1:0]       dir_q, out_q, pin_sync, rx_field;
    logic [SLOT_BITS-1:0]  tx_q;
    pwr_state_t            pwr;
    logic                  pwr_ready;
    logic                  wr_dir, wr_pwr, wr_irq;
    logic                  unused_slot_low;

    assign addr            = reg_addr_e'(reg_addr);
    assign wr_dir          = reg_we && (addr == RA_DIR);
    assign wr_pwr          = reg_we && (addr == RA_PWR);
    assign wr_irq          = reg_we && (addr == RA_IRQ);
    assign rx_field        = rx_slot[SLOT_BITS-1:LO];
    assign unused_slot_low = ^rx_slot[LO-1:0];
    assign pwr_ready       = pwr.ready;

    fsg_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    fsg_power #(.SETTLE(SETTLE)) u_power (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .wr_en     (wr_pwr),
        .wr_pd     (reg_wdata[PWR_PD_BIT]),
        .state     (pwr)
    );

    fsg_change_irq #(.W(NPIN)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .lvl    (pin_sync),
        .watch  (~dir_q),
        .enable (pwr_ready),
        .clr    (wr_irq && reg_wdata[0]),
        .flag   (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
            tx_q  <= '0;
        end else begin
            if (wr_dir) dir_q <= reg_wdata[NPIN-1:0];
            if (frame_stb) begin
                out_q <= (out_q & ~dir_q) | (rx_field & dir_q);
                tx_q  <= pwr_ready ? {pin_sync & ~dir_q, {LO{1'b0}}} : '0;
            end
        end
    end

    assign tx_slot = tx_q;
    assign pad_oe  = pwr_ready ? dir_q : '0;
    assign pad_out = out_q & pad_oe;

    always_comb begin
        unique case (addr)
            RA_DIR:  reg_rdata = REG_W'(dir_q);
            RA_PWR:  reg_rdata = pwr_word(pwr);
            RA_IRQ:  reg_rdata = REG_W'(irq);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fslot_gpio_chk.sv
module fslot_gpio_chk #(
    parameter int NPIN      = 16,
    parameter int SLOT_BITS = 20
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_stb,
    input logic                 reg_we,
    input logic [1:0]           reg_addr,
    input logic [15:0]          reg_wdata,
    input logic [15:0]          reg_rdata,
    input logic [SLOT_BITS-1:0] tx_slot,
    input logic [NPIN-1:0]      pad_oe,
    input logic                 irq,
    input logic                 pwr_ready,
    input logic [NPIN-1:0]      out_q,
    input logic [NPIN-1:0]      dir_q
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && tx_slot == '0 && !irq));

    // R3
    a_r3_input_bits_ignored: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0));

    // R4
    a_r4_status_held: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(tx_slot));

    a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        tx_slot[3:0] == 4'h0);

    // R6
    a_r6_released_when_not_ready: assert property (@(posedge clk) disable iff (rst)
        !pwr_ready |-> pad_oe == '0);

    // R7
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd1) |-> ((reg_rdata & 16'hFEFE) == 16'h0000));

    // R8
    a_r8_ready_on_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_ready) |-> $past(frame_stb));

    // R10
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !(reg_we && reg_addr == 2'd2 && reg_wdata[0])) |=> irq);
endmodule

bind fslot_gpio_ctrl fslot_gpio_chk #(.NPIN(NPIN), .SLOT_BITS(SLOT_BITS)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tx_slot   (tx_slot),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .pwr_ready (pwr_ready),
    .out_q     (out_q),
    .dir_q     (dir_q)
);

// File: tb/test_fslot_gpio_ctrl.sv
module test_fslot_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic [19:0] rx_slot = '0;
    logic [19:0] tx_slot;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] pad_in, pad_out, pad_oe, ext_in = '0;
    logic        loopback = 1'b0;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign pad_in = loopback ? {pad_out[7:0], 8'h00} : ext_in;

    fslot_gpio_ctrl i_fslot_gpio_ctrl (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_slot(rx_slot),
        .tx_slot(tx_slot), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic frame(input logic [15:0] field, input logic [3:0] low);
        @(negedge clk);
        frame_stb = 1'b1; rx_slot = {field, low};
        @(negedge clk);
        frame_stb = 1'b0;
        idle(4);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk("R1 tx_slot", 32'(tx_slot), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rd(2'd0, d); chk("R1 dir", 32'(d), 32'h0);
        rd(2'd1, d); chk("R7 pwr reset", 32'(d), 32'h0100);
    endtask

    task automatic t_power_up;
        logic [15:0] d;
        wr(2'd1, 16'h0000);
        frame(16'h0, 4'h0);
        frame(16'h0, 4'h0);
        rd(2'd1, d); chk("R8 not ready after 2", 32'(d), 32'h0000);
        frame(16'h0, 4'h0);
        rd(2'd1, d); chk("R8 ready after 3", 32'(d), 32'h0001);
    endtask

    task automatic t_dir;
        logic [15:0] d;
        wr(2'd0, 16'hC3A5);
        rd(2'd0, d); chk("R11 dir readback", 32'(d), 32'hC3A5);
        wr(2'd0, 16'h00FF);
        rd(2'd0, d); chk("R11 dir readback 2", 32'(d), 32'h00FF);
    endtask

    task automatic t_outputs;
        frame(16'h005A, 4'hF);
        chk("R2 pad_oe", 32'(pad_oe), 32'h00FF);
        chk("R2 pad_out", 32'(pad_out), 32'h005A);
        frame(16'h00A5, 4'h0);
        chk("R2 pad_out next", 32'(pad_out), 32'h00A5);
    endtask

    task automatic t_ignore;
        frame(16'hFF00, 4'h0);
        chk("R3 outputs cleared", 32'(pad_out), 32'h0000);
        wr(2'd0, 16'hFFFF);
        chk("R3 ignored bits absent", 32'(pad_out), 32'h0000);
        frame(16'hA55A, 4'h0);
        chk("R2 all outputs", 32'(pad_out), 32'hA55A);
        wr(2'd0, 16'h00FF);
    endtask

    task automatic t_status;
        ext_in = 16'h3CFF;
        idle(3);
        frame(16'h0000, 4'h0);
        chk("R4 status", 32'(tx_slot), 32'h3C000);
        ext_in = 16'h8100;
        idle(1);
        chk("R4 held", 32'(tx_slot), 32'h3C000);
        idle(3);
        frame(16'h0000, 4'h0);
        chk("R4 refreshed", 32'(tx_slot), 32'h81000);
    endtask

    task automatic t_latency;
        loopback = 1'b1;
        frame(16'h0000, 4'h0);
        frame(16'h0000, 4'h0);
        frame(16'h0011, 4'h0);
        chk("R5 same frame", 32'(tx_slot), 32'h00000);
        frame(16'h0011, 4'h0);
        chk("R5 next frame", 32'(tx_slot), 32'h11000);
        loopback = 1'b0;
        ext_in = 16'h0000;
        idle(4);
    endtask

    task automatic t_irq;
        wr(2'd2, 16'h0001);
        idle(1);
        chk("R10 cleared", 32'(irq), 32'h0);
        ext_in = 16'h00F0;
        idle(5);
        chk("R9 output pin ignored", 32'(irq), 32'h0);
        ext_in = 16'h04F0;
        idle(5);
        chk("R9 input change", 32'(irq), 32'h1);
        ext_in = 16'h0000;
        idle(5);
        wr(2'd2, 16'h0000);
        idle(2);
        chk("R10 write 0 keeps", 32'(irq), 32'h1);
        begin
            logic [15:0] d;
            rd(2'd2, d); chk("R10 readback", 32'(d), 32'h0001);
        end
        wr(2'd2, 16'h0001);
        idle(1);
        chk("R10 write 1 clears", 32'(irq), 32'h0);
    endtask

    task automatic t_powerdown;
        logic [15:0] d;
        wr(2'd1, 16'hFFFF);
        idle(2);
        rd(2'd1, d); chk("R7 reserved bits", 32'(d), 32'h0100);
        chk("R6 pad_oe", 32'(pad_oe), 32'h0);
        chk("R6 pad_out", 32'(pad_out), 32'h0);
        ext_in = 16'h5500;
        idle(4);
        frame(16'h00FF, 4'h0);
        chk("R6 status zero", 32'(tx_slot), 32'h0);
        chk("R9 no irq when down", 32'(irq), 32'h0);
        chk("R8 ready cleared", 32'(reg_rdata[0]), 32'h0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset;
        t_power_up;
        t_dir;
        t_outputs;
        t_ignore;
        t_status;
        t_latency;
        t_irq;
        t_powerdown;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule